// File: doc/BRIEF.md
# CSMA/CD Half-Duplex Nibble Transmit Sequencer

This block places one Ethernet frame at a time onto a 4-bit media-independent transmit interface on a shared, half-duplex medium. The host raises a start strobe, then presents the frame body (destination address through payload) one nibble per cycle, marking the final nibble with an end strobe. On the wire the block emits the preamble, the start-of-frame delimiter, the host nibbles, zero padding when the frame is short, and a 32-bit frame check sequence that it computes itself.

Before each attempt the block defers to carrier and waits out the inter-frame gap. A collision during an attempt causes a jam, a random backoff and a retry from the preamble. Frames are dropped on a late collision, on too many collisions, on a host underrun, on an oversized frame, or when the medium stays busy for too long. Each frame ends with a one-cycle status pulse that carries a result code. On a retry, a one-cycle pulse tells the host to rewind its nibble stream to the first data nibble.

Top module: `csma_tx`

## Requirements
- R1: While reset is asserted and until a start strobe arrives, transmit enable, the status pulse, the consume strobe and the rewind pulse all stay low.
- R2: Every attempt begins with 15 nibbles of value 0x5 followed by one nibble of 0xD, with transmit enable high throughout.
- R3: After the delimiter, each host nibble with its valid high is put on the wire in the same cycle, its consume strobe high, in host order, with no gaps.
- R4: One nibble count covers preamble, delimiter, data and pad. If the end strobe comes while that count is below 136, zero nibbles follow until it reaches 136.
- R5: After the data and any pad, 8 FCS nibbles follow: the complement of a CRC-32 (reflected polynomial 0xEDB88320, all-ones start, each nibble fed least significant bit first) over data and pad, least significant nibble first. Transmit enable then falls, and a status pulse with code 0 follows in the next cycle.
- R6: Transmission of an attempt starts only after 24 consecutive cycles with carrier low and transmit enable low. Carrier high restarts that count, so the first preamble nibble appears 25 cycles after carrier falls.
- R7: If the block has waited to transmit for twice the nibble time of a maximum-length frame, it drops the frame without driving the wire and reports code 5.
- R8: A collision during an attempt, while fewer than one slot of data nibbles (128 by default) has gone out, ends the attempt. The block sends exactly 8 jam nibbles and raises the rewind pulse on the last of them. After a random wait of r slots, with r uniform in 0 to 2^min(n,10)-1 for collision count n, and then a fresh gap, it restarts from the preamble. The idle time between attempts is at least 25 cycles and at most 27 + (2^min(n,10)-1) times the slot length.
- R9: A collision seen once the data count has reached one slot is late. The block sends the 8 jam nibbles, does not retry, and reports code 1.
- R10: The 16th collision on one frame drops it after the jam, with code 2, after exactly 15 rewind pulses.
- R11: A missing host nibble (valid low) during the data phase drops transmit enable in that same cycle and reports code 3.
- R12: A frame whose data phase would exceed the maximum frame size minus the FCS (3028 nibbles by default) stops at that limit and reports code 4. A frame of exactly that size completes with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sof | input | 1 | Start strobe for a new frame |
| tx_valid | input | 1 | Host nibble present on tx_nib |
| tx_eof | input | 1 | Host nibble is the last of the frame |
| tx_nib | input | 4 | Host data nibble |
| tx_used | output | 1 | Host nibble taken this cycle |
| tx_retry | output | 1 | Rewind the host stream to the first data nibble |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| mii_txen | output | 1 | Transmit enable to the PHY |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| status_vld | output | 1 | One-cycle frame result strobe |
| status | output | 3 | Result code, valid with status_vld |

## Verification
The sequencer is driven with a short frame that needs padding, and with long frames that need none. These show whether the pad decision is taken from the combined count, and whether the FCS covers pad nibbles. Collisions are placed one nibble either side of the slot boundary, which separates retry from late drop. A repeated collision on every attempt checks the attempt limit and the backoff window as it widens. Held carrier, a starved host, and frames at and beyond the size limit each exercise one separate termination path.

// File: rtl/csma_tx.sv
module csma_tx #(
  parameter int IFG_NIB         = 24,
  parameter int SLOT_NIB        = 128,
  parameter int MAX_FRAME_BYTES = 1518,
  parameter int MIN_LEN_NIB     = 136,
  parameter int JAM_NIB         = 8,
  parameter int MAX_ATTEMPTS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_sof,
  input  logic       tx_valid,
  input  logic       tx_eof,
  input  logic [3:0] tx_nib,
  output logic       tx_used,
  output logic       tx_retry,
  input  logic       crs,
  input  logic       col,
  output logic       mii_txen,
  output logic [3:0] mii_txd,
  output logic       status_vld,
  output logic [2:0] status
);

  localparam int MAX_LEN   = 16 + 2 * (MAX_FRAME_BYTES - 4);
  localparam int DEFER_LIM = 2 * (16 + 2 * MAX_FRAME_BYTES);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int DW = $clog2(DEFER_LIM + 1);
  localparam int IW = $clog2(IFG_NIB + 1);
  localparam int SW = $clog2(SLOT_NIB);
  localparam int CW = ($clog2(MAX_ATTEMPTS + 1) < 4) ? 4 : $clog2(MAX_ATTEMPTS + 1);

  localparam logic [LW-1:0] MAX_V     = LW'(MAX_LEN);
  localparam logic [LW-1:0] MIN_V     = LW'(MIN_LEN_NIB);
  localparam logic [LW-1:0] LATE_V    = LW'(16 + SLOT_NIB);
  localparam logic [DW-1:0] DEFER_V   = DW'(DEFER_LIM);
  localparam logic [IW-1:0] IFG_V     = IW'(IFG_NIB);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_NIB - 1);
  localparam logic [3:0]    JAM_LAST  = 4'(JAM_NIB - 1);
  localparam logic [CW-1:0] ATT_LAST  = CW'(MAX_ATTEMPTS - 1);

  localparam logic [2:0] ST_OK = 3'd0, ST_LATE = 3'd1, ST_XCOL = 3'd2,
                         ST_UNDER = 3'd3, ST_XLEN = 3'd4, ST_DEFER = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_DEFER, S_PRE, S_SFD, S_DATA, S_PAD, S_FCS, S_JAM, S_BACK, S_DONE
  } state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] x;
    x = c;
    for (int i = 0; i < 4; i++)
      x = (x[0] ^ d[i]) ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    return x;
  endfunction

  state_t        state;
  logic [LW-1:0] len_cnt;
  logic [DW-1:0] defer_cnt;
  logic [IW-1:0] ifg_cnt;
  logic [3:0]    nib_cnt;
  logic [CW-1:0] coll_cnt;
  logic [9:0]    slots;
  logic [SW-1:0] tick;
  logic [15:0]   lfsr;
  logic [31:0]   crc;
  logic          late;
  logic [9:0]    bo_mask;
  logic [CW-1:0] coll_next;
  logic [31:0]   fcs_word;

  wire ifg_ok   = (ifg_cnt == IFG_V);
  wire in_frame = state inside {S_PRE, S_SFD, S_DATA, S_PAD, S_FCS};
  wire too_long = (state == S_DATA) && (len_cnt == MAX_V);
  wire starved  = (state == S_DATA) && !tx_valid;
  wire jam_last = (state == S_JAM) && (nib_cnt == JAM_LAST);
  wire give_up  = (coll_cnt == ATT_LAST);

  assign coll_next  = coll_cnt + CW'(1);
  assign fcs_word   = ~crc;
  assign mii_txen   = (in_frame || state == S_JAM) && !too_long && !starved;
  assign tx_used    = mii_txen && (state == S_DATA);
  assign tx_retry   = jam_last && !late && !give_up;
  assign status_vld = (state == S_DONE);

  always_comb begin
    if (coll_next >= CW'(10)) bo_mask = '1;
    else bo_mask = (10'd1 << coll_next) - 10'd1;
  end

  always_comb begin
    case (state)
      S_PRE:   mii_txd = 4'h5;
      S_SFD:   mii_txd = 4'hD;
      S_DATA:  mii_txd = tx_nib;
      S_FCS:   mii_txd = fcs_word[{nib_cnt[2:0], 2'b00} +: 4];
      S_JAM:   mii_txd = 4'h6;
      default: mii_txd = 4'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      len_cnt   <= '0;
      defer_cnt <= '0;
      ifg_cnt   <= '0;
      nib_cnt   <= '0;
      coll_cnt  <= '0;
      slots     <= '0;
      tick      <= '0;
      lfsr      <= 16'hACE1;
      crc       <= '1;
      late      <= 1'b0;
      status    <= ST_OK;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};
      if (crs || mii_txen) ifg_cnt <= '0;
      else if (!ifg_ok) ifg_cnt <= ifg_cnt + IW'(1);
      defer_cnt <= (state == S_DEFER) ? defer_cnt + DW'(1) : '0;

      if (in_frame && col) begin
        state   <= S_JAM;
        nib_cnt <= '0;
        late    <= (len_cnt >= LATE_V);
      end else begin
        case (state)
          S_IDLE: if (tx_sof) begin
            state    <= S_DEFER;
            coll_cnt <= '0;
          end
          S_DEFER: if (ifg_ok) begin
            state   <= S_PRE;
            nib_cnt <= '0;
            len_cnt <= '0;
            crc     <= '1;
          end else if (defer_cnt == DEFER_V) begin
            state  <= S_DONE;
            status <= ST_DEFER;
          end
          S_PRE: begin
            len_cnt <= len_cnt + LW'(1);
            nib_cnt <= nib_cnt + 4'd1;
            if (nib_cnt == 4'd14) state <= S_SFD;
          end
          S_SFD: begin
            len_cnt <= len_cnt + LW'(1);
            state   <= S_DATA;
          end
          S_DATA: if (too_long) begin
            state  <= S_DONE;
            status <= ST_XLEN;
          end else if (!tx_valid) begin
            state  <= S_DONE;
            status <= ST_UNDER;
          end else begin
            crc     <= crc_step(crc, tx_nib);
            len_cnt <= len_cnt + LW'(1);
            if (tx_eof) begin
              nib_cnt <= '0;
              state   <= (len_cnt >= MIN_V - LW'(1)) ? S_FCS : S_PAD;
            end
          end
          S_PAD: begin
            crc     <= crc_step(crc, 4'h0);
            len_cnt <= len_cnt + LW'(1);
            if (len_cnt == MIN_V - LW'(1)) begin
              state   <= S_FCS;
              nib_cnt <= '0;
            end
          end
          S_FCS: begin
            nib_cnt <= nib_cnt + 4'd1;
            if (nib_cnt == 4'd7) begin
              state  <= S_DONE;
              status <= ST_OK;
            end
          end
          S_JAM: begin
            nib_cnt <= nib_cnt + 4'd1;
            if (jam_last) begin
              if (late) begin
                state  <= S_DONE;
                status <= ST_LATE;
              end else if (give_up) begin
                coll_cnt <= coll_next;
                state    <= S_DONE;
                status   <= ST_XCOL;
              end else begin
                coll_cnt <= coll_next;
                slots    <= lfsr[9:0] & bo_mask;
                tick     <= '0;
                state    <= S_BACK;
              end
            end
          end
          S_BACK: if (slots == 10'd0) state <= S_DEFER;
          else if (tick == SLOT_LAST) begin
            tick  <= '0;
            slots <= slots - 10'd1;
          end else tick <= tick + SW'(1);
          S_DONE:  state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> mii_txd == 4'h5) else $error("preamble start"); // R2
  AST_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> $past(ifg_ok)) else $error("gap not met"); // R6
  AST_PAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FCS |-> len_cnt >= MIN_V) else $error("short frame"); // R4
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mii_txen |-> len_cnt <= MAX_V) else $error("frame too long"); // R12
  AST_COLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    coll_cnt <= CW'(MAX_ATTEMPTS)) else $error("attempts"); // R10
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry |=> !mii_txen) else $error("retry overlap"); // R8

endmodule

// File: tb/csma_tx_bench.sv
module csma_tx_bench;
  localparam int IFG  = 24;
  localparam int SLOT = 8;
  localparam int MAXB = 100;
  localparam int MAXD = 2 * (MAXB - 4);

  logic clk = 1'b0;
  logic rst_n, tx_sof, tx_valid, tx_eof, crs, col;
  logic [3:0] tx_nib;
  logic tx_used, tx_retry, mii_txen, status_vld;
  logic [3:0] mii_txd;
  logic [2:0] status;

  always #5 clk = ~clk;

  csma_tx #(.IFG_NIB(IFG), .SLOT_NIB(SLOT), .MAX_FRAME_BYTES(MAXB)) u_csma_tx (
    .clk(clk), .rst_n(rst_n), .tx_sof(tx_sof), .tx_valid(tx_valid), .tx_eof(tx_eof),
    .tx_nib(tx_nib), .tx_used(tx_used), .tx_retry(tx_retry), .crs(crs), .col(col),
    .mii_txen(mii_txen), .mii_txd(mii_txd), .status_vld(status_vld), .status(status));

  int n_chk = 0, n_fail = 0;
  logic [3:0] frame [0:255];
  logic [3:0] wire_log [0:511];
  int n_data, col_at, col_left, starve_at, crs_hold;
  int wire_n, tx_total, st_got, got_vld, retries, jam_len, gap_bad, first_rise;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      logic [3:0] d = (k < n_data) ? frame[k] : 4'h0;
      for (int b = 0; b < 4; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic run_frame();
    int idx = 0, gap = 0, after_col = -1;
    bit used_p = 0, retry_p = 0, col_done = 0;
    wire_n = 0; tx_total = 0; retries = 0; jam_len = -1; gap_bad = 0;
    first_rise = -1; got_vld = 0; st_got = -1;
    @(negedge clk);
    tx_sof = 1'b1; crs = (crs_hold > 0); tx_valid = 1'b0; col = 1'b0;
    for (int cyc = 1; cyc < 120000 && got_vld == 0; cyc++) begin
      @(negedge clk);
      tx_sof = 1'b0;
      if (retry_p) begin idx = 0; col_done = 0; wire_n = 0; end
      else if (used_p) idx++;
      crs = (cyc < crs_hold);
      tx_valid = (idx < n_data) && (idx != starve_at);
      tx_nib = frame[idx & 255];
      tx_eof = (idx == n_data - 1);
      col = (col_left > 0) && !col_done && (idx == col_at) && (wire_n >= 16);
      if (col) begin col_done = 1; col_left--; after_col = 0; end
      #1;
      used_p = tx_used; retry_p = tx_retry;
      if (tx_retry) retries++;
      if (mii_txen) begin
        if (wire_n < 512) wire_log[wire_n] = mii_txd;
        wire_n++; tx_total++;
        if (first_rise < 0) first_rise = cyc;
        if (after_col >= 0 && !col) after_col++;
        if (gap > 0) begin
          int m = (retries >= 10) ? 1023 : (1 << retries) - 1;
          if (gap < IFG + 1 || gap > IFG + 3 + m * SLOT) gap_bad++;
          gap = 0;
        end
      end else begin
        if (after_col >= 0) begin jam_len = after_col; after_col = -1; end
        if (retries > 0) gap++;
      end
      if (status_vld) begin got_vld = 1; st_got = int'(status); end
    end
    @(negedge clk);
    crs = 1'b0; col = 1'b0; tx_valid = 1'b0; tx_eof = 1'b0;
  endtask

  task automatic setup(input int n);
    n_data = n; col_at = -1; col_left = 0; starve_at = -1; crs_hold = 0;
    for (int i = 0; i < 256; i++) frame[i] = 4'((i * 7 + 3 + n) % 16);
  endtask

  task automatic expect_frame(input int n, input string tag);
    int body = (n < 120) ? 120 : n;
    int bad_pre = 0, bad_dat = 0, bad_pad = 0, bad_fcs = 0;
    logic [31:0] f = ref_crc(body);
    for (int i = 0; i < 16; i++)
      if (wire_log[i] != ((i == 15) ? 4'hD : 4'h5)) bad_pre++;
    for (int i = 0; i < body; i++)
      if (i < n) begin if (wire_log[16 + i] != frame[i]) bad_dat++; end
      else if (wire_log[16 + i] != 4'h0) bad_pad++;
    for (int i = 0; i < 8; i++)
      if (wire_log[16 + body + i] != f[4*i +: 4]) bad_fcs++;
    chk(wire_n == 16 + body + 8, "R4", {tag, " nibble count"}, wire_n, 16 + body + 8);
    chk(bad_pre == 0, "R2", {tag, " preamble errors"}, bad_pre, 0);
    chk(bad_dat == 0, "R3", {tag, " data errors"}, bad_dat, 0);
    chk(bad_pad == 0, "R4", {tag, " pad errors"}, bad_pad, 0);
    chk(bad_fcs == 0, "R5", {tag, " fcs errors"}, bad_fcs, 0);
    chk(st_got == 0, "R5", {tag, " status"}, st_got, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_sof = 0; tx_valid = 0; tx_eof = 0; crs = 0; col = 0; tx_nib = 4'h0;
    repeat (3) @(negedge clk);
    #1;
    chk(!mii_txen && !status_vld && !tx_used && !tx_retry, "R1", "outputs in reset",
        int'({mii_txen, status_vld, tx_used, tx_retry}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (30) @(negedge clk);
    #1;
    chk(!mii_txen && !status_vld, "R1", "idle without start", int'({mii_txen, status_vld}), 0);
  endtask

  task automatic t_short();
    setup(20); run_frame(); expect_frame(20, "short");
  endtask

  task automatic t_long();
    setup(150); run_frame(); expect_frame(150, "long");
  endtask

  task automatic t_gap();
    setup(20); crs_hold = 40; run_frame();
    chk(first_rise == crs_hold + IFG + 1, "R6", "first txen cycle", first_rise, crs_hold + IFG + 1);
  endtask

  task automatic t_defer();
    setup(20); crs_hold = 1000; run_frame();
    chk(st_got == 5, "R7", "defer status", st_got, 5);
    chk(tx_total == 0, "R7", "nibbles sent", tx_total, 0);
  endtask

  task automatic t_early(input int at);
    setup(30); col_at = at; col_left = 1; run_frame();
    chk(jam_len == 8, "R8", "jam length", jam_len, 8);
    chk(retries == 1, "R8", "rewind pulses", retries, 1);
    chk(gap_bad == 0, "R8", "backoff gap out of window", gap_bad, 0);
    expect_frame(30, "retried");
  endtask

  task automatic t_late();
    setup(30); col_at = SLOT; col_left = 1; run_frame();
    chk(st_got == 1, "R9", "late status", st_got, 1);
    chk(retries == 0, "R9", "rewind pulses", retries, 0);
    chk(jam_len == 8, "R9", "jam length", jam_len, 8);
  endtask

  task automatic t_xcol();
    setup(30); col_at = 2; col_left = 16; run_frame();
    chk(st_got == 2, "R10", "excess collision status", st_got, 2);
    chk(retries == 15, "R10", "rewind pulses", retries, 15);
    chk(gap_bad == 0, "R8", "growing backoff window", gap_bad, 0);
  endtask

  task automatic t_under();
    setup(60); starve_at = 30; run_frame();
    chk(st_got == 3, "R11", "underrun status", st_got, 3);
    chk(tx_total == 46, "R11", "nibbles before drop", tx_total, 46);
  endtask

  task automatic t_length();
    setup(200); run_frame();
    chk(st_got == 4, "R12", "oversize status", st_got, 4);
    chk(tx_total == 16 + MAXD, "R12", "nibbles before stop", tx_total, 16 + MAXD);
    setup(MAXD); run_frame();
    chk(st_got == 0, "R12", "max size status", st_got, 0);
    chk(wire_n == 16 + MAXD + 8, "R12", "max size nibbles", wire_n, 16 + MAXD + 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_long();
    t_gap();
    t_defer();
    t_early(3);
    t_early(SLOT - 1);
    t_late();
    t_xcol();
    t_under();
    t_length();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule